// File: doc/BRIEF.md
# PHY Initialization Pulse Sequencer

This block runs the start-up handshake that a storage-interface PHY needs after its clock or timing settings change. Software programs one 32-bit timing-adjust register over a simple register bus. The register holds four 4-bit phase lengths and two plain mode bits. Software then sets the trigger bit. The sequencer asserts a synchronizer-enable strobe, waits an interval, and asserts a synchronizer-reset strobe. It then counts a settling time and a fixed tail before it clears the trigger bit on its own.

Software detects completion by polling the trigger bit until it reads zero. Hardware neighbours can use the busy level and the one-cycle done pulse instead. While the sequence runs, the register is frozen, so the phase lengths in use cannot change halfway through.

Top module: `phyinit_seq`

## Requirements
- R1: After reset the register reads 0x00000000, and busy_o, done_o, sync_en_o and sync_rst_o are all low.
- R2: A write to REG_ADDR while idle stores the bits [15:0], 28, 29 and 31 of the write data. All other bits read as zero. A read of REG_ADDR returns the register on reg_rdata_o one cycle after the read strobe. Reads of any other address return zero, and writes to any other address are ignored.
- R3: A write that sets bit 31 while idle starts the sequence. busy_o rises in the next cycle and stays high for exactly E+G+R+W+8 cycles, where the field values are E = bits [11:8], G = bits [7:4], R = bits [3:0] and W = bits [15:12].
- R4: sync_en_o is high for the first E busy cycles.
- R5: sync_rst_o is high for R cycles, starting E+G cycles after busy_o rises.
- R6: A phase whose field is zero takes no cycles, and its strobe never rises.
- R7: Bit 31 reads as one while the sequence is busy. It clears in the first cycle that busy_o is low again. done_o is high for exactly that one cycle.
- R8: Register writes while busy are ignored, including a repeated write of one to bit 31. The busy time and the stored fields are unchanged.
- R9: Bit 29 drives slow_mode_o and bit 28 drives sdio_mode_o. The sequence never alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| sync_en_o | output | 1 | Synchronizer-enable strobe |
| sync_rst_o | output | 1 | Synchronizer-reset strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| slow_mode_o | output | 1 | Slow-mode control bit |
| sdio_mode_o | output | 1 | SDIO-mode control bit |

## Verification
The assertions assume that the bus strobes are free of X after reset. They also assume that a start is only ever caused by a bus write, so busy_o can rise only after such a write. The field checks take it as given that the register can change only while idle, so the phase lengths feeding the strobes stay fixed for a whole run. The stimulus keeps to these assumptions: it drives every bus input from tasks at the falling edge, holds each strobe for a single cycle, and, while busy, issues only the writes that the block must ignore.

// File: rtl/phyinit_pkg.sv
`timescale 1ns/1ps
package phyinit_pkg;
    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 4;
    localparam int NFIELDS  = 4;
    localparam int FLDS_W   = FIELD_W * NFIELDS;

    // bit positions software and the sequencer agree on
    localparam int TRIG_BIT = 31;
    localparam int SLOW_BIT = 29;
    localparam int SDIO_BIT = 28;
    localparam int RST_LSB  = 0;
    localparam int GAP_LSB  = 4;
    localparam int EN_LSB   = 8;
    localparam int WAIT_LSB = 12;

    localparam logic [DATA_W-1:0] WMASK =
        (DATA_W'(1) << TRIG_BIT) | (DATA_W'(1) << SLOW_BIT) |
        (DATA_W'(1) << SDIO_BIT) | ((DATA_W'(1) << FLDS_W) - DATA_W'(1));

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_EN   = 3'd1,
        PH_GAP  = 3'd2,
        PH_RST  = 3'd3,
        PH_WAIT = 3'd4,
        PH_TAIL = 3'd5
    } phase_e;

    localparam int NPH = 6;
endpackage

// File: rtl/phyinit_regs.sv
`timescale 1ns/1ps
module phyinit_regs
    import phyinit_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h70
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                busy_i,
    input  logic                finish_i,
    output logic                start_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [FLDS_W-1:0]   fields_o,
    output logic                slow_o,
    output logic                sdio_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] rdata;
    } rs_t;

    rs_t rs_d, rs_q;
    logic hit, wr_ok;

    always_comb begin
        rs_d   = rs_q;
        hit    = (addr_i == REG_ADDR);
        wr_ok  = wr_i && hit && !busy_i;
        start_o = wr_ok && wdata_i[TRIG_BIT];
        if (wr_ok) begin
            rs_d.cfg = wdata_i & WMASK;
        end
        if (finish_i) begin
            rs_d.cfg[TRIG_BIT] = 1'b0;
        end
        rs_d.rdata = (rd_i && hit) ? rs_q.cfg : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rs_q <= '0;
        else         rs_q <= rs_d;
    end

    assign rdata_o  = rs_q.rdata;
    assign fields_o = rs_q.cfg[FLDS_W-1:0];
    assign slow_o   = rs_q.cfg[SLOW_BIT];
    assign sdio_o   = rs_q.cfg[SDIO_BIT];

    // R8
    fields_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> $stable(rs_q.cfg[FLDS_W-1:0]));
    // R9
    mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> ($stable(slow_o) && $stable(sdio_o)));
    // R7
    trig_set_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> rs_q.cfg[TRIG_BIT]);
endmodule

// File: rtl/phyinit_pick.sv
`timescale 1ns/1ps
module phyinit_pick
    import phyinit_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int TAIL_CYCLES = 8
) (
    input  phase_e              cur_i,
    input  logic [FLDS_W-1:0]   fields_i,
    output phase_e              nxt_o,
    output logic [CNT_W-1:0]    load_o
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] len [NPH];
    logic found;

    always_comb begin
        len[0] = '0;
        len[1] = LEN_W'(fields_i[EN_LSB   +: FIELD_W]);
        len[2] = LEN_W'(fields_i[GAP_LSB  +: FIELD_W]);
        len[3] = LEN_W'(fields_i[RST_LSB  +: FIELD_W]);
        len[4] = LEN_W'(fields_i[WAIT_LSB +: FIELD_W]);
        len[5] = LEN_W'(TAIL_CYCLES);
        nxt_o  = PH_IDLE;
        load_o = '0;
        found  = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            if (!found && (i > int'(cur_i)) && (len[i] != '0)) begin
                found  = 1'b1;
                nxt_o  = phase_e'(3'(i));
                load_o = CNT_W'(len[i] - LEN_W'(1));
            end
        end
    end
endmodule

// File: rtl/phyinit_fsm.sv
`timescale 1ns/1ps
module phyinit_fsm
    import phyinit_pkg::*;
#(
    parameter int TAIL_CYCLES = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [FLDS_W-1:0]   fields_i,
    output logic                finish_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                sync_en_o,
    output logic                sync_rst_o
);
    localparam int TAIL_W = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1;
    localparam int CNT_W  = (FIELD_W > TAIL_W) ? FIELD_W : TAIL_W;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } st_t;

    st_t st_d, st_q;
    phase_e nxt;
    logic [CNT_W-1:0] load;

    phyinit_pick #(.CNT_W(CNT_W), .TAIL_CYCLES(TAIL_CYCLES)) u_pick (
        .cur_i   (st_q.phase),
        .fields_i(fields_i),
        .nxt_o   (nxt),
        .load_o  (load)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        finish_o  = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start_i) begin
                st_d.phase = nxt;
                st_d.cnt   = load;
            end
        end else if (st_q.cnt == '0) begin
            st_d.phase = nxt;
            st_d.cnt   = load;
            if (nxt == PH_IDLE) begin
                finish_o  = 1'b1;
                st_d.done = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        else         st_q <= st_d;
    end

    assign busy_o     = (st_q.phase != PH_IDLE);
    assign done_o     = st_q.done;
    assign sync_en_o  = (st_q.phase == PH_EN);
    assign sync_rst_o = (st_q.phase == PH_RST);

    // R3
    start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));
    // R7
    done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);
    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R6
    en_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_en_o |-> (fields_i[EN_LSB +: FIELD_W] != '0));
    // R6
    rst_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_rst_o |-> (fields_i[RST_LSB +: FIELD_W] != '0));
endmodule

// File: rtl/phyinit_seq.sv
`timescale 1ns/1ps
module phyinit_seq
    import phyinit_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h70,
    parameter int TAIL_CYCLES = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                sync_en_o,
    output logic                sync_rst_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                slow_mode_o,
    output logic                sdio_mode_o
);
    logic start, finish;
    logic [FLDS_W-1:0] fields_q, fields_eff;

    phyinit_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .busy_i  (busy_o),
        .finish_i(finish),
        .start_o (start),
        .rdata_o (reg_rdata_o),
        .fields_o(fields_q),
        .slow_o  (slow_mode_o),
        .sdio_o  (sdio_mode_o)
    );

    // a starting write supplies the phase lengths before they land in the register
    assign fields_eff = start ? reg_wdata_i[FLDS_W-1:0] : fields_q;

    phyinit_fsm #(.TAIL_CYCLES(TAIL_CYCLES)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .fields_i  (fields_eff),
        .finish_o  (finish),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .sync_en_o (sync_en_o),
        .sync_rst_o(sync_rst_o)
    );
endmodule

// File: tb/tb_phyinit_seq.sv
`timescale 1ns/1ps
module tb_phyinit_seq;
    localparam logic [7:0] RA = 8'h70;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic sen, srst, busy, done, slow, sdio;
    int total = 0, bad = 0, busy_cnt = 0;

    always #4 clk = ~clk;

    phyinit_seq dut (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .sync_en_o(sen), .sync_rst_o(srst), .busy_o(busy), .done_o(done),
        .slow_mode_o(slow), .sdio_mode_o(sdio)
    );

    always @(posedge clk) if (busy) busy_cnt <= busy_cnt + 1;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(!busy && !done && !sen && !srst, "R1 outputs", {busy, done, sen, srst}, 0);
        bus_rd(RA, v);
        chk(v == 32'h0, "R1 reg", v, 32'h0);
    endtask

    task automatic t_regrw();
        logic [31:0] v;
        bus_wr(RA, 32'h7FFF_FFFF);
        bus_rd(RA, v);
        chk(v == 32'h3000_FFFF, "R2 mask", v, 32'h3000_FFFF);
        chk(slow && sdio, "R9 mode out", {slow, sdio}, 2'b11);
        bus_wr(8'h10, 32'h0000_1234);
        bus_rd(RA, v);
        chk(v == 32'h3000_FFFF, "R2 other addr write", v, 32'h3000_FFFF);
        bus_rd(8'h10, v);
        chk(v == 32'h0, "R2 other addr read", v, 32'h0);
        bus_wr(RA, 32'h0);
    endtask

    // one full run; checks every cycle against the phase arithmetic
    task automatic t_seq(input logic [31:0] d, input string tag);
        int e, g, r, w, t;
        logic [31:0] v;
        r = int'(d[3:0]); g = int'(d[7:4]); e = int'(d[11:8]); w = int'(d[15:12]);
        t = e + g + r + w + 8;
        bus_wr(RA, d | 32'h8000_0000);
        for (int i = 0; i <= t + 1; i++) begin
            chk(busy == (i < t), {"R3 busy ", tag}, busy, (i < t));
            chk(done == (i == t), {"R7 done ", tag}, done, (i == t));
            chk(sen == (i < e), {"R4 R6 en ", tag}, sen, (i < e));
            chk(srst == (i >= e + g && i < e + g + r), {"R5 R6 rst ", tag}, srst,
                (i >= e + g && i < e + g + r));
            chk(slow == d[29] && sdio == d[28], {"R9 ", tag}, {slow, sdio}, d[29:28]);
            @(negedge clk);
        end
        bus_rd(RA, v);
        chk(v == (d & 32'h3000_FFFF), {"R7 trig cleared ", tag}, v, d & 32'h3000_FFFF);
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        int lim;
        busy_cnt = 0;
        bus_wr(RA, 32'h8000_FFFF);
        bus_rd(RA, v);
        chk(v == 32'h8000_FFFF, "R7 trig while busy", v, 32'h8000_FFFF);
        bus_wr(RA, 32'hB000_0001);
        bus_wr(RA, 32'h0000_1111);
        bus_rd(RA, v);
        chk(v == 32'h8000_FFFF, "R8 write ignored", v, 32'h8000_FFFF);
        lim = 0;
        while (!done && lim < 500) begin @(negedge clk); lim++; end
        chk(busy_cnt == 68, "R8 busy length", busy_cnt, 68);
        bus_rd(RA, v);
        chk(v == 32'h0000_FFFF, "R8 fields kept", v, 32'h0000_FFFF);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regrw();
        t_seq(32'h0000_1234, "mixed");
        t_seq(32'h2000_FFFF, "max");
        t_seq(32'h1000_0000, "all zero");
        t_seq(32'h0000_0F0F, "no gap");
        t_seq(32'h3000_00F0, "gap only");
        t_busy_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule